// File: doc/BRIEF.md
# System Reset Source Controller

This block produces the chip-wide active-low system reset from four origins: power-up, an external reset pad, a software-serviced watchdog and a clock-loss monitor. It drives an open-drain reset pad low during internally started resets and watches the same pad to find out whether something outside the chip is holding it. After power-up it keeps the system in reset for a fixed settling delay measured in E-clock cycles.

Every internal reset follows the same sequence. The block pulls the pad low for a fixed number of cycles, lets it go, waits a few cycles and then looks at the pad again. If the pad is still low, an outside agent owns the reset. The block records the reset as external and holds the system in reset until the pad goes high. If the pad is high, the internal cause is recorded instead.

The watchdog period is the E clock divided by a fixed power of two and then by a selectable scale. The clock monitor runs on a separate free-running reference clock, so it can raise reset even after the E clock has stopped.

Top module: `rst_source_ctrl`

## Requirements
- R1: When `por_n` deasserts, `sys_rst_n` stays low for exactly POR_CYCLES (default 4064) E-clock rising edges and then goes high. After that, `rst_cause` reads 2'b00 (power) and `rst_external` reads 0.
- R2: A low level on the pad seen for fewer than EXT_MIN+1 (default 5) consecutive synchronized samples causes no reset.
- R3: A low pad that passes the length filter but is high at the confirmation sample, EXT_CONF (default 2) cycles later, causes no reset.
- R4: A low pad that is still low at the confirmation sample asserts reset without driving the pad. Reset is held until the pad is high again. Afterwards `rst_cause` reads 2'b01 (external) and `rst_external` reads 1.
- R5: Every internal reset drives `pin_drive_low` for exactly DRIVE_CYC (default 4) consecutive cycles, and `sys_rst_n` is low throughout.
- R6: After the pad is released, the block waits SETTLE_CYC (default 2) cycles plus the synchronizer depth and then samples the pad. If it is high, the internal cause is recorded and `rst_external` is 0. If it is low, the reset is recorded as external (2'b01, `rst_external`=1) and held until the pad is high.
- R7: The watchdog times out 2^WD_PRE_LOG2 × {1, 2, 4, 4} cycles after its last service, for `wd_rate` = 0, 1, 2, 3. The count runs from the edge that accepts the servicing write to the edge at which `pin_drive_low` rises. The resulting cause is 2'b10.
- R8: Only a write of 8'h55 followed directly by a write of 8'hAA services the watchdog. A lone 8'hAA write does not restart the count, and neither does a sequence with a different write in between.
- R9: `wd_disable` is taken in only while system reset is active. A change made while running has no effect until the next reset.
- R10: With `cm_enable` high, if no E-clock edge occurs for 2^CM_W−1 reference-clock cycles, `sys_rst_n` goes low without needing the E clock. Once the clock resumes, an internal sequence completes and `rst_cause` reads 2'b11.
- R11: With `cm_enable` low, stopping the E clock does not affect `sys_rst_n`.
- R12: `rst_cause` keeps its value for as long as the system stays out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_e | input | 1 | E clock |
| ref_clk | input | 1 | Free-running reference clock for the clock monitor |
| por_n | input | 1 | Power-good / oscillator-active, low = power-on reset |
| pin_in | input | 1 | Level seen on the open-drain reset pad |
| pin_drive_low | output | 1 | Pulls the reset pad low when 1 |
| sys_rst_n | output | 1 | System reset, active low |
| rst_cause | output | 2 | Cause of last reset: 00 power, 01 external, 10 watchdog, 11 clock monitor |
| rst_external | output | 1 | 1 when the last reset was recognised as coming from outside |
| wd_wr_en | input | 1 | Write strobe for the watchdog service register |
| wd_wr_data | input | 8 | Watchdog service write data |
| wd_disable | input | 1 | Watchdog off request, applied at the next reset |
| wd_rate | input | 2 | Watchdog scale select |
| cm_enable | input | 1 | Clock monitor enable |

## Verification
The bench sweeps every watchdog scale code, including the duplicate top code. A wrong scale or an off-by-one in the count shows up as a timeout cycle count that differs from the arithmetic value. Two short pad pulses sit just below the length filter and just inside it but released before confirmation. A design that skipped the filter or the confirmation sample would reset on them. A pad held low across an internal drive/release/sample window checks that the cause flips to external; a design sampling too early or ignoring the pad would report the watchdog instead. Stopping the E clock with the monitor enabled and then disabled checks that reset appears without any E edge. The bench also toggles the watchdog-off bit mid-run, where a design that applied it at once would miss the expected timeout.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

   typedef enum logic [1:0] {
      CAUSE_POWER  = 2'b00,
      CAUSE_EXT    = 2'b01,
      CAUSE_WDOG   = 2'b10,
      CAUSE_CLKMON = 2'b11
   } rst_cause_e;

   typedef enum logic [2:0] {
      SQ_POR,
      SQ_RUN,
      SQ_CONFIRM,
      SQ_DRIVE,
      SQ_SETTLE,
      SQ_HOLD
   } seq_state_e;

   localparam logic [7:0] WD_KEY_ARM  = 8'h55;
   localparam logic [7:0] WD_KEY_FIRE = 8'hAA;

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("rstc_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= RESET_VAL;
            else        stage_q <= d;
         end
         assign q = stage_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], d};
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rstc_watchdog.sv
module rstc_watchdog
   import rstc_pkg::*;
#(
   parameter int PRE_LOG2 = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       cfg_off,
   input  logic [1:0] rate,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic       expire
);

   localparam int CW = PRE_LOG2 + 3;

   generate
      if (PRE_LOG2 < 1 || PRE_LOG2 > 28) begin : g_bad_pre
         $error("rstc_watchdog: PRE_LOG2 out of range");
      end
   endgenerate

   logic          en_q;
   logic          armed_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit_m1;
   logic          service;

   // scale code 3 repeats the largest scale
   always_comb begin
      unique case (rate)
         2'd0:    limit_m1 = (CW'(1) << PRE_LOG2) - CW'(1);
         2'd1:    limit_m1 = (CW'(1) << (PRE_LOG2 + 1)) - CW'(1);
         default: limit_m1 = (CW'(1) << (PRE_LOG2 + 2)) - CW'(1);
      endcase
   end

   assign service = run && wr_en && (wr_data == WD_KEY_FIRE) && armed_q;
   assign expire  = run && en_q && !service && (cnt_q >= limit_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         if (!run) begin
            en_q <= !cfg_off;
         end

         if (!run) begin
            armed_q <= 1'b0;
         end else if (wr_en) begin
            armed_q <= (wr_data == WD_KEY_ARM);
         end

         if (!run || !en_q || service) begin
            cnt_q <= '0;
         end else if (cnt_q < limit_m1) begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

endmodule

// File: rtl/rstc_clkmon.sv
module rstc_clkmon #(
   parameter int CM_W = 8,
   parameter int SYNC = 2
) (
   input  logic clk_e,
   input  logic ref_clk,
   input  logic rst_n,
   input  logic enable,
   output logic cm_flag,
   output logic req_pulse
);

   generate
      if (CM_W < 2) begin : g_bad_width
         $error("rstc_clkmon: CM_W must be at least 2");
      end
   endgenerate

   // E-clock side: activity toggle and request capture
   logic tgl_q;
   logic req_s;
   logic req_q;

   always_ff @(posedge clk_e or negedge rst_n) begin
      if (!rst_n) begin
         tgl_q <= 1'b0;
         req_q <= 1'b0;
      end else begin
         tgl_q <= !tgl_q;
         req_q <= req_s;
      end
   end

   assign req_pulse = req_s && !req_q;

   rstc_sync #(.STAGES(SYNC), .RESET_VAL(1'b0)) u_req_sync (
      .clk   (clk_e),
      .rst_n (rst_n),
      .d     (cm_flag),
      .q     (req_s)
   );

   // reference side: edge detection, timeout count, sticky flag
   logic            tgl_s;
   logic            tgl_d;
   logic            en_s;
   logic            ack_s;
   logic [CM_W-1:0] cnt_q;
   logic            seen_edge;
   logic            timeout;

   rstc_sync #(.STAGES(SYNC), .RESET_VAL(1'b0)) u_tgl_sync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     (tgl_q),
      .q     (tgl_s)
   );

   rstc_sync #(.STAGES(SYNC), .RESET_VAL(1'b0)) u_en_sync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     (enable),
      .q     (en_s)
   );

   rstc_sync #(.STAGES(SYNC), .RESET_VAL(1'b0)) u_ack_sync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     (req_s),
      .q     (ack_s)
   );

   assign seen_edge = tgl_s ^ tgl_d;
   assign timeout   = &cnt_q;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         tgl_d   <= 1'b0;
         cnt_q   <= '0;
         cm_flag <= 1'b0;
      end else begin
         tgl_d <= tgl_s;

         if (seen_edge || !en_s) begin
            cnt_q <= '0;
         end else if (!timeout) begin
            cnt_q <= cnt_q + CM_W'(1);
         end

         if (ack_s) begin
            cm_flag <= 1'b0;
         end else if (timeout && en_s) begin
            cm_flag <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
   import rstc_pkg::*;
#(
   parameter int POR_CYCLES = 4064,
   parameter int DRIVE_CYC  = 4,
   parameter int SETTLE_CYC = 2,
   parameter int SYNC       = 2,
   parameter int EXT_MIN    = 4,
   parameter int EXT_CONF   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_s,
   input  logic       req_wd,
   input  logic       req_cm,
   output logic       drive_low,
   output logic       in_reset,
   output logic       run,
   output logic [1:0] cause,
   output logic       external
);

   localparam int SAMPLE_AT = SETTLE_CYC + SYNC;
   localparam int CNT_W     = $clog2(POR_CYCLES + DRIVE_CYC + SAMPLE_AT + EXT_CONF + 1);
   localparam int LOW_W     = $clog2(EXT_MIN + 1);

   generate
      if (POR_CYCLES < 1 || DRIVE_CYC < 1 || EXT_CONF < 1) begin : g_bad_len
         $error("rstc_seq: cycle counts must be at least 1");
      end
      if (EXT_MIN < 1) begin : g_bad_min
         $error("rstc_seq: EXT_MIN must be at least 1");
      end
   endgenerate

   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [LOW_W-1:0] low_q;
   rst_cause_e       pend_q;
   rst_cause_e       cause_q;
   logic             ext_q;
   logic             int_req;
   rst_cause_e       req_cause;

   assign int_req   = req_wd || req_cm;
   assign req_cause = req_cm ? CAUSE_CLKMON : CAUSE_WDOG;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_POR;
         cnt_q   <= '0;
         low_q   <= '0;
         pend_q  <= CAUSE_POWER;
         cause_q <= CAUSE_POWER;
         ext_q   <= 1'b0;
      end else begin
         unique case (state_q)
            SQ_POR: begin
               if (cnt_q == CNT_W'(POR_CYCLES - 1)) begin
                  state_q <= SQ_RUN;
                  cnt_q   <= '0;
                  low_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            SQ_RUN: begin
               if (int_req) begin
                  state_q <= SQ_DRIVE;
                  cnt_q   <= '0;
                  pend_q  <= req_cause;
               end else if (!pin_s) begin
                  if (low_q == LOW_W'(EXT_MIN)) begin
                     state_q <= SQ_CONFIRM;
                     cnt_q   <= '0;
                  end else begin
                     low_q <= low_q + LOW_W'(1);
                  end
               end else begin
                  low_q <= '0;
               end
            end
            SQ_CONFIRM: begin
               if (int_req) begin
                  state_q <= SQ_DRIVE;
                  cnt_q   <= '0;
                  pend_q  <= req_cause;
               end else if (cnt_q == CNT_W'(EXT_CONF - 1)) begin
                  cnt_q <= '0;
                  low_q <= '0;
                  if (!pin_s) begin
                     state_q <= SQ_HOLD;
                     cause_q <= CAUSE_EXT;
                     ext_q   <= 1'b1;
                  end else begin
                     state_q <= SQ_RUN;
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            SQ_DRIVE: begin
               if (cnt_q == CNT_W'(DRIVE_CYC - 1)) begin
                  state_q <= SQ_SETTLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            SQ_SETTLE: begin
               if (cnt_q == CNT_W'(SAMPLE_AT - 1)) begin
                  cnt_q <= '0;
                  low_q <= '0;
                  if (!pin_s) begin
                     state_q <= SQ_HOLD;
                     cause_q <= CAUSE_EXT;
                     ext_q   <= 1'b1;
                  end else begin
                     state_q <= SQ_RUN;
                     cause_q <= pend_q;
                     ext_q   <= 1'b0;
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            SQ_HOLD: begin
               if (pin_s) begin
                  state_q <= SQ_RUN;
                  low_q   <= '0;
               end
            end
            default: begin
               state_q <= SQ_POR;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign drive_low = (state_q == SQ_DRIVE);
   assign run       = (state_q == SQ_RUN) || (state_q == SQ_CONFIRM);
   assign in_reset  = !run;
   assign cause     = cause_q;
   assign external  = ext_q;

endmodule

// File: rtl/rst_source_ctrl.sv
module rst_source_ctrl #(
   parameter int POR_CYCLES  = 4064,
   parameter int DRIVE_CYC   = 4,
   parameter int SETTLE_CYC  = 2,
   parameter int EXT_MIN     = 4,
   parameter int EXT_CONF    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int WD_PRE_LOG2 = 15,
   parameter int CM_W        = 8
) (
   input  logic       clk_e,
   input  logic       ref_clk,
   input  logic       por_n,
   input  logic       pin_in,
   output logic       pin_drive_low,
   output logic       sys_rst_n,
   output logic [1:0] rst_cause,
   output logic       rst_external,
   input  logic       wd_wr_en,
   input  logic [7:0] wd_wr_data,
   input  logic       wd_disable,
   input  logic [1:0] wd_rate,
   input  logic       cm_enable
);

   logic pin_s;
   logic wd_expire;
   logic cm_flag;
   logic cm_req;
   logic seq_in_reset;
   logic seq_run;

   rstc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pin_sync (
      .clk   (clk_e),
      .rst_n (por_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   rstc_seq #(
      .POR_CYCLES (POR_CYCLES),
      .DRIVE_CYC  (DRIVE_CYC),
      .SETTLE_CYC (SETTLE_CYC),
      .SYNC       (SYNC_STAGES),
      .EXT_MIN    (EXT_MIN),
      .EXT_CONF   (EXT_CONF)
   ) u_seq (
      .clk       (clk_e),
      .rst_n     (por_n),
      .pin_s     (pin_s),
      .req_wd    (wd_expire),
      .req_cm    (cm_req),
      .drive_low (pin_drive_low),
      .in_reset  (seq_in_reset),
      .run       (seq_run),
      .cause     (rst_cause),
      .external  (rst_external)
   );

   rstc_watchdog #(.PRE_LOG2(WD_PRE_LOG2)) u_wd (
      .clk     (clk_e),
      .rst_n   (por_n),
      .run     (seq_run),
      .cfg_off (wd_disable),
      .rate    (wd_rate),
      .wr_en   (wd_wr_en),
      .wr_data (wd_wr_data),
      .expire  (wd_expire)
   );

   rstc_clkmon #(.CM_W(CM_W), .SYNC(SYNC_STAGES)) u_cm (
      .clk_e     (clk_e),
      .ref_clk   (ref_clk),
      .rst_n     (por_n),
      .enable    (cm_enable),
      .cm_flag   (cm_flag),
      .req_pulse (cm_req)
   );

   // the monitor flag lives on the reference clock so reset can assert with E stopped
   assign sys_rst_n = !(seq_in_reset || cm_flag);

endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
   parameter int DRIVE_CYC  = 4,
   parameter int POR_CYCLES = 4064
) (
   input logic       clk_e,
   input logic       por_n,
   input logic       sys_rst_n,
   input logic       pin_drive_low,
   input logic [1:0] rst_cause,
   input logic       wd_expire
);

   localparam int RUN_W = $clog2(DRIVE_CYC + 2);
   localparam int POR_W = $clog2(POR_CYCLES + 1);

   logic [RUN_W-1:0] drv_run;
   logic [POR_W-1:0] por_cnt;

   always_ff @(posedge clk_e or negedge por_n) begin
      if (!por_n) begin
         drv_run <= '0;
         por_cnt <= '0;
      end else begin
         drv_run <= pin_drive_low ? drv_run + RUN_W'(1) : '0;
         if (por_cnt < POR_W'(POR_CYCLES)) por_cnt <= por_cnt + POR_W'(1);
      end
   end

   p_por_hold_r1: assert property (@(posedge clk_e) disable iff (!por_n)
      (por_cnt < POR_W'(POR_CYCLES)) |-> !sys_rst_n);

   p_drive_len_r5: assert property (@(posedge clk_e) disable iff (!por_n)
      $fell(pin_drive_low) |-> (drv_run == RUN_W'(DRIVE_CYC)));

   p_drive_in_reset_r5: assert property (@(posedge clk_e) disable iff (!por_n)
      pin_drive_low |-> !sys_rst_n);

   p_wd_expire_drive_r7: assert property (@(posedge clk_e) disable iff (!por_n)
      wd_expire |=> pin_drive_low);

   p_cause_hold_r12: assert property (@(posedge clk_e) disable iff (!por_n)
      (sys_rst_n && $past(sys_rst_n)) |-> $stable(rst_cause));

endmodule

bind rst_source_ctrl rstc_checker #(
   .DRIVE_CYC  (DRIVE_CYC),
   .POR_CYCLES (POR_CYCLES)
) u_rstc_checker (
   .clk_e         (clk_e),
   .por_n         (por_n),
   .sys_rst_n     (sys_rst_n),
   .pin_drive_low (pin_drive_low),
   .rst_cause     (rst_cause),
   .wd_expire     (wd_expire)
);

// File: tb/rst_source_ctrl_bench.sv
`timescale 1ns/1ps
module rst_source_ctrl_bench;

   localparam int POR_N  = 4064;
   localparam int PRE    = 6;
   localparam int CMW    = 4;
   localparam int DRV    = 4;
   localparam int WD_KEY_A = 8'h55;
   localparam int WD_KEY_B = 8'hAA;

   logic       clk_e = 1'b0;
   logic       ref_clk = 1'b0;
   logic       clk_run = 1'b1;
   logic       por_n = 1'b0;
   logic       ext_low = 1'b0;
   logic       pin_in;
   logic       pin_drive_low;
   logic       sys_rst_n;
   logic [1:0] rst_cause;
   logic       rst_external;
   logic       wd_wr_en = 1'b0;
   logic [7:0] wd_wr_data = 8'h00;
   logic       wd_disable = 1'b0;
   logic [1:0] wd_rate = 2'd0;
   logic       cm_enable = 1'b1;

   int tests = 0;
   int fails = 0;

   // open-drain pad with pull-up
   assign pin_in = !(pin_drive_low || ext_low);

   initial forever begin
      #10;
      if (clk_run) clk_e = !clk_e;
   end

   initial forever #4 ref_clk = !ref_clk;

   rst_source_ctrl #(
      .POR_CYCLES  (POR_N),
      .DRIVE_CYC   (DRV),
      .WD_PRE_LOG2 (PRE),
      .CM_W        (CMW)
   ) u_rst_source_ctrl (
      .clk_e         (clk_e),
      .ref_clk       (ref_clk),
      .por_n         (por_n),
      .pin_in        (pin_in),
      .pin_drive_low (pin_drive_low),
      .sys_rst_n     (sys_rst_n),
      .rst_cause     (rst_cause),
      .rst_external  (rst_external),
      .wd_wr_en      (wd_wr_en),
      .wd_wr_data    (wd_wr_data),
      .wd_disable    (wd_disable),
      .wd_rate       (wd_rate),
      .cm_enable     (cm_enable)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wd_write(input int data, inout int c);
      @(negedge clk_e);
      wd_wr_en   = 1'b1;
      wd_wr_data = 8'(data);
      @(negedge clk_e);
      wd_wr_en   = 1'b0;
      c += 2;
   endtask

   task automatic service();
      int dummy = 0;
      wd_write(WD_KEY_A, dummy);
      wd_write(WD_KEY_B, dummy);
   endtask

   task automatic wait_drive(inout int c);
      int guard = 0;
      while (!pin_drive_low && guard < 3000) begin
         @(negedge clk_e);
         c++;
         guard++;
      end
   endtask

   task automatic drive_len(output int d);
      d = 0;
      while (pin_drive_low && d < 100) begin
         @(negedge clk_e);
         d++;
      end
   endtask

   task automatic wait_release(output int c);
      c = 0;
      while (!sys_rst_n && c < 6000) begin
         @(negedge clk_e);
         c++;
      end
   endtask

   task automatic pulse_no_reset(input int n, input string req);
      int lows = 0;
      ext_low = 1'b1;
      repeat (n) @(negedge clk_e);
      ext_low = 1'b0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk_e);
         if (!sys_rst_n) lows++;
      end
      chk(req, lows, 0);
   endtask

   initial begin
      #(20.0 * 200000);
      fails++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int c, d, r;
      int bad;

      // R1: power-on hold
      #95;
      chk("R1 reset low during por", int'(sys_rst_n), 0);
      chk("R1 pad idle during por", int'(pin_drive_low), 0);
      @(negedge clk_e);
      por_n = 1'b1;
      wait_release(c);
      chk("R1 por hold length", c, POR_N);
      chk("R1 cause power", int'(rst_cause), 0);
      chk("R1 not external", int'(rst_external), 0);

      // R7 R5 R6: every scale code
      for (int rate = 0; rate < 4; rate++) begin
         wd_rate = 2'(rate);
         service();
         c = 0;
         wait_drive(c);
         chk($sformatf("R7 timeout rate %0d", rate), c, (1 << PRE) << ((rate > 2) ? 2 : rate));
         drive_len(d);
         chk("R5 drive length", d, DRV);
         wait_release(r);
         chk("R6 internal cause watchdog", int'(rst_cause), 2);
         chk("R6 internal flag", int'(rst_external), 0);
      end

      // R8: lone fire key does not service
      wd_rate = 2'd0;
      service();
      c = 0;
      repeat (20) begin @(negedge clk_e); c++; end
      wd_write(WD_KEY_B, c);
      wait_drive(c);
      chk("R8 lone AA ignored", c, 1 << PRE);
      wait_release(r);

      // R8: interrupted sequence does not service
      service();
      c = 0;
      wd_write(WD_KEY_A, c);
      wd_write(8'h12, c);
      wd_write(WD_KEY_B, c);
      wait_drive(c);
      chk("R8 interrupted sequence ignored", c, 1 << PRE);
      wait_release(r);

      // R9: disable while running has no effect yet
      service();
      c = 0;
      wd_disable = 1'b1;
      wait_drive(c);
      chk("R9 disable deferred", c, 1 << PRE);
      wait_release(r);
      bad = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk_e);
         if (pin_drive_low || !sys_rst_n) bad++;
      end
      chk("R9 disabled after reset", bad, 0);
      wd_disable = 1'b0;
      bad = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk_e);
         if (pin_drive_low || !sys_rst_n) bad++;
      end
      chk("R9 enable deferred", bad, 0);

      // R2, R3: short pad pulses
      pulse_no_reset(4, "R2 short pulse filtered");
      pulse_no_reset(5, "R3 released before confirm");

      // R11: monitor disabled
      cm_enable = 1'b0;
      repeat (10) @(negedge clk_e);
      clk_run = 1'b0;
      #400;
      chk("R11 no reset with monitor off", int'(sys_rst_n), 1);
      clk_run = 1'b1;
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk_e);
         if (!sys_rst_n) bad++;
      end
      chk("R11 no reset after resume", bad, 0);

      // R10: monitor enabled, clock stops
      cm_enable = 1'b1;
      repeat (10) @(negedge clk_e);
      clk_run = 1'b0;
      #400;
      chk("R10 reset without E clock", int'(sys_rst_n), 0);
      clk_run = 1'b1;
      @(negedge clk_e);
      wait_release(r);
      chk("R10 cause clock monitor", int'(rst_cause), 3);
      chk("R10 internal flag", int'(rst_external), 0);

      // R9 enable took effect at that reset; R12 cause holds while running
      service();
      c = 0;
      bad = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk_e);
         c++;
         if (rst_cause != 2'd3) bad++;
      end
      chk("R12 cause holds", bad, 0);
      wait_drive(c);
      chk("R9 enabled after next reset", c, 1 << PRE);
      wait_release(r);

      // R4: long external pulse
      service();
      ext_low = 1'b1;
      bad = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk_e);
         if (pin_drive_low) bad++;
      end
      chk("R4 reset held while pad low", int'(sys_rst_n), 0);
      chk("R4 pad not driven", bad, 0);
      ext_low = 1'b0;
      wait_release(r);
      chk("R4 cause external", int'(rst_cause), 1);
      chk("R4 external flag", int'(rst_external), 1);

      // R6: pad held by outside during internal sequence
      service();
      c = 0;
      wait_drive(c);
      ext_low = 1'b1;
      repeat (20) @(negedge clk_e);
      chk("R6 held while outside low", int'(sys_rst_n), 0);
      ext_low = 1'b0;
      wait_release(r);
      chk("R6 cause external", int'(rst_cause), 1);
      chk("R6 external flag", int'(rst_external), 1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule